// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recent page translations and turns a virtual address into a physical address in one registered cycle. Every stored page tag is compared in parallel with the page part of the incoming address. A match returns the stored frame number with the page offset appended. A lookup with no match raises a fault to the requester, which is expected to walk its page tables and then install the translation through the fill port.

Each slot carries a valid flag, a modified flag and an accessed flag. Use of a slot marks it accessed, and a write that hits marks it modified. An external command clears all accessed flags at once. The refill logic uses the accessed flags to choose a slot to replace. A flush input drops every translation in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, no slot is valid. Lookups then fault, and `rsp_valid`, `rsp_hit` and `rsp_fault` are low after reset.
- R2: A lookup accepted with `lk_valid` gives `rsp_valid` high exactly one cycle later. On a hit, `rsp_hit` is 1 and `rsp_paddr` is the stored frame number in bits [PFN_W+OFS_W-1:OFS_W] above the untouched offset bits [OFS_W-1:0].
- R3: A lookup that matches no valid slot gives `rsp_fault`=1, `rsp_hit`=0, `rsp_paddr`=0 and `rsp_modified`=0.
- R4: A fill loads the slot's modified flag from `fill_dirty`. A hit with `lk_write`=1 sets it, and a read hit leaves it unchanged. `rsp_modified` shows the flag as it stands after the access.
- R5: When at least one slot is invalid, a fill of a new page goes to the invalid slot with the lowest index.
- R6: When all slots are valid, a fill of a new page replaces the lowest-index slot whose accessed flag is clear.
- R7: When all slots are valid and all are accessed, a fill of a new page replaces slot 0.
- R8: A hit and a fill each set the slot's accessed flag. `clr_acc` clears all accessed flags, but a hit in the same cycle keeps its own flag set.
- R9: A fill whose page number is already held rewrites that slot in place. No other slot is disturbed.
- R10: A fill in the same cycle as `flush` is discarded.
- R11: The offset width OFS_W is between 11 and 14 bits, which gives pages of 2 KB to 16 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every slot |
| clr_acc | input | 1 | Clear all accessed flags |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_dirty | input | 1 | Initial modified flag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | No translation, fault |
| rsp_paddr | output | PFN_W+OFS_W | Physical address (zero on fault) |
| rsp_modified | output | 1 | Modified flag of the hit slot after this access |

## Verification
The hardest case to reach is replacement by accessed flag. That case needs a completely full buffer with a chosen pattern of set and clear accessed flags. The victim's identity is also visible only indirectly, as an older translation that starts to fault. The stimulus fills all eight slots in a known order and clears the accessed flags while touching slot 0 in the same cycle. It then touches two more slots and installs a new page. Lookups then show that the fourth-filled page was evicted and its neighbours were kept. A full buffer with every flag set is used first to show the fallback to slot 0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DEF_SLOTS = 8;
  localparam int DEF_VPN_W = 16;
  localparam int DEF_PFN_W = 12;
  localparam int DEF_OFS_W = 11;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 16,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]            valid,
  input  logic [SLOTS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic                        any,
  output logic [IDX_W-1:0]            idx
);
  logic [SLOTS-1:0] hit_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  assign any = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int SLOTS = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] valid,
  input  logic [SLOTS-1:0] accessed,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] free_idx, stale_idx;
  logic             any_free, any_stale;

  always_comb begin
    free_idx  = '0;
    stale_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!valid[i])    free_idx  = IDX_W'(i);
      if (!accessed[i]) stale_idx = IDX_W'(i);
    end
  end

  assign any_free  = ~&valid;
  assign any_stale = ~&accessed;

  always_comb begin
    if (any_free)       idx = free_idx;
    else if (any_stale) idx = stale_idx;
    else                idx = '0;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int SLOTS = DEF_SLOTS,
  parameter int VPN_W = DEF_VPN_W,
  parameter int PFN_W = DEF_PFN_W,
  parameter int OFS_W = DEF_OFS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   clr_acc,
  input  logic                   lk_valid,
  input  logic                   lk_write,
  input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   fill_dirty,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic [PFN_W+OFS_W-1:0] rsp_paddr,
  output logic                   rsp_modified
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PA_W  = PFN_W + OFS_W;

  logic [SLOTS-1:0][VPN_W-1:0] tag_q;
  logic [SLOTS-1:0][PFN_W-1:0] pfn_q;
  logic [SLOTS-1:0]            valid_q, mod_q, acc_q;
  logic [SLOTS-1:0]            valid_n, mod_n, acc_n;

  logic [VPN_W-1:0] lk_vpn;
  logic [OFS_W-1:0] lk_ofs;
  logic             lk_any, fl_any, fill_en;
  logic [IDX_W-1:0] lk_idx, fl_idx, vic_idx, wr_idx;

  rsp_kind_e        kind_q;
  logic [PA_W-1:0]  paddr_q;
  logic             rvalid_q, rmod_q;

  assign lk_vpn = lk_vaddr[VPN_W+OFS_W-1:OFS_W];
  assign lk_ofs = lk_vaddr[OFS_W-1:0];

  tlb_match #(.SLOTS(SLOTS), .TAG_W(VPN_W)) u_lk_match (
    .valid (valid_q),
    .tags  (tag_q),
    .key   (lk_vpn),
    .any   (lk_any),
    .idx   (lk_idx)
  );

  tlb_match #(.SLOTS(SLOTS), .TAG_W(VPN_W)) u_fill_match (
    .valid (valid_q),
    .tags  (tag_q),
    .key   (fill_vpn),
    .any   (fl_any),
    .idx   (fl_idx)
  );

  tlb_victim #(.SLOTS(SLOTS)) u_victim (
    .valid    (valid_q),
    .accessed (acc_q),
    .idx      (vic_idx)
  );

  assign fill_en = fill_valid && !flush;
  assign wr_idx  = fl_any ? fl_idx : vic_idx;

  always_comb begin
    valid_n = valid_q;
    mod_n   = mod_q;
    acc_n   = acc_q;
    if (clr_acc) acc_n = '0;
    if (lk_valid && lk_any) begin
      acc_n[lk_idx] = 1'b1;
      if (lk_write) mod_n[lk_idx] = 1'b1;
    end
    if (fill_en) begin
      valid_n[wr_idx] = 1'b1;
      mod_n[wr_idx]   = fill_dirty;
      acc_n[wr_idx]   = 1'b1;
    end
    if (flush) valid_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      mod_q   <= '0;
      acc_q   <= '0;
    end else begin
      valid_q <= valid_n;
      mod_q   <= mod_n;
      acc_q   <= acc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[wr_idx] <= fill_vpn;
      pfn_q[wr_idx] <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      kind_q   <= RSP_IDLE;
      paddr_q  <= '0;
      rmod_q   <= 1'b0;
    end else begin
      rvalid_q <= lk_valid;
      if (lk_valid && lk_any) begin
        kind_q  <= RSP_HIT;
        paddr_q <= {pfn_q[lk_idx], lk_ofs};
        rmod_q  <= mod_q[lk_idx] | lk_write;
      end else if (lk_valid) begin
        kind_q  <= RSP_FAULT;
        paddr_q <= '0;
        rmod_q  <= 1'b0;
      end else begin
        kind_q  <= RSP_IDLE;
        paddr_q <= '0;
        rmod_q  <= 1'b0;
      end
    end
  end

  assign rsp_valid    = rvalid_q;
  assign rsp_hit      = (kind_q == RSP_HIT);
  assign rsp_fault    = (kind_q == RSP_FAULT);
  assign rsp_paddr    = paddr_q;
  assign rsp_modified = rmod_q;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VPN_W = 16,
  parameter int PFN_W = 12,
  parameter int OFS_W = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   flush,
  input logic                   lk_valid,
  input logic                   lk_write,
  input logic [VPN_W+OFS_W-1:0] lk_vaddr,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   rsp_fault,
  input logic [PFN_W+OFS_W-1:0] rsp_paddr,
  input logic                   rsp_modified
);
  initial begin
    p_page_size_r11: assert (OFS_W >= 11 && OFS_W <= 14)
      else $error("page offset width out of range");
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rsp_hit -> rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_fault));

  p_fault_clean_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_modified));

  p_write_dirty_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_write) |=> (rsp_hit -> rsp_modified));

  p_flush_empty_r1: assert property (@(posedge clk) disable iff (rst)
    flush |=> (lk_valid |=> rsp_fault));
endmodule

bind xlat_tlb tlb_checker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .lk_valid     (lk_valid),
  .lk_write     (lk_write),
  .lk_vaddr     (lk_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_fault    (rsp_fault),
  .rsp_paddr    (rsp_paddr),
  .rsp_modified (rsp_modified)
);

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
  localparam int VPN_W = 16;
  localparam int PFN_W = 12;
  localparam int OFS_W = 11;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   flush = 1'b0, clr_acc = 1'b0;
  logic                   lk_valid = 1'b0, lk_write = 1'b0;
  logic [VPN_W+OFS_W-1:0] lk_vaddr = '0;
  logic                   fill_valid = 1'b0, fill_dirty = 1'b0;
  logic [VPN_W-1:0]       fill_vpn = '0;
  logic [PFN_W-1:0]       fill_pfn = '0;
  logic                   rsp_valid, rsp_hit, rsp_fault, rsp_modified;
  logic [PFN_W+OFS_W-1:0] rsp_paddr;

  always #2.5 clk = ~clk;

  xlat_tlb dut_i (
    .clk(clk), .rst(rst), .flush(flush), .clr_acc(clr_acc),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_dirty(fill_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_modified(rsp_modified)
  );

  typedef struct {
    logic                   hit;
    logic [PFN_W+OFS_W-1:0] paddr;
    logic                   modified;
    string                  req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFS_W-1:0] ofs,
                        input bit wr, input bit clr, input bit eh,
                        input logic [PFN_W-1:0] epfn, input bit em, input string req);
    exp_t e;
    e.hit      = eh;
    e.paddr    = eh ? {epfn, ofs} : '0;
    e.modified = eh ? em : 1'b0;
    e.req      = req;
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_write = wr; lk_vaddr = {vpn, ofs}; clr_acc = clr;
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0; clr_acc = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                      input bit dirty, input bit with_flush);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_dirty = dirty;
    flush = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
  endtask

  // monitor: pop expected items as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected response: got hit=%0b fault=%0b, expected none", rsp_hit, rsp_fault);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_fault !== !e.hit ||
            rsp_paddr !== e.paddr || rsp_modified !== e.modified) begin
          n_bad++;
          $display("FAIL %s: got hit=%0b fault=%0b paddr=%h mod=%0b, expected hit=%0b fault=%0b paddr=%h mod=%0b",
                   e.req, rsp_hit, rsp_fault, rsp_paddr, rsp_modified,
                   e.hit, !e.hit, e.paddr, e.modified);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected stimulus to finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state: got v=%0b h=%0b f=%0b, expected 0 0 0", rsp_valid, rsp_hit, rsp_fault);
    end
    lookup(16'h0005, 11'h001, 0, 0, 0, '0, 0, "R1 empty after reset");

    // R5 slots fill in index order while free
    fill(16'h0010, 12'h101, 0, 0);   // slot 0
    fill(16'h0020, 12'h202, 1, 0);   // slot 1
    lookup(16'h0010, 11'h3AB, 0, 0, 1, 12'h101, 0, "R2 hit paddr");
    lookup(16'h0020, 11'h055, 0, 0, 1, 12'h202, 1, "R4 fill dirty loaded");
    lookup(16'h0010, 11'h7FF, 1, 0, 1, 12'h101, 1, "R4 write hit sets modified");
    lookup(16'h0010, 11'h000, 0, 0, 1, 12'h101, 1, "R4 read keeps modified");
    lookup(16'h0030, 11'h123, 0, 0, 0, '0, 0, "R3 miss faults");

    fill(16'h0040, 12'h404, 0, 0);   // slot 2
    fill(16'h0050, 12'h505, 0, 0);   // slot 3
    fill(16'h0060, 12'h606, 0, 0);   // slot 4
    fill(16'h0070, 12'h707, 0, 0);   // slot 5
    fill(16'h0080, 12'h808, 0, 0);   // slot 6
    fill(16'h0090, 12'h909, 0, 0);   // slot 7
    lookup(16'h0090, 11'h010, 0, 0, 1, 12'h909, 0, "R5 last free slot used");

    // R9 refill of a held page stays in place
    fill(16'h0020, 12'h2EE, 0, 0);
    lookup(16'h0020, 11'h011, 0, 0, 1, 12'h2EE, 0, "R9 in-place rewrite");
    lookup(16'h0010, 11'h012, 0, 0, 1, 12'h101, 1, "R9 other slot kept");

    // R7 full and all accessed: slot 0 replaced
    fill(16'h00A0, 12'hAAA, 0, 0);
    lookup(16'h0010, 11'h013, 0, 0, 0, '0, 0, "R7 slot 0 evicted");
    lookup(16'h00A0, 11'h014, 0, 0, 1, 12'hAAA, 0, "R7 new page in slot 0");

    // R8/R6 clear accessed, touching slot 0 in the same cycle
    lookup(16'h00A0, 11'h015, 0, 1, 1, 12'hAAA, 0, "R8 hit with clear");
    lookup(16'h0020, 11'h016, 0, 0, 1, 12'h2EE, 0, "R8 touch slot 1");
    lookup(16'h0040, 11'h017, 0, 0, 1, 12'h404, 0, "R8 touch slot 2");
    fill(16'h00B0, 12'hBBB, 0, 0);
    lookup(16'h0050, 11'h018, 0, 0, 0, '0, 0, "R6 first stale slot evicted");
    lookup(16'h00B0, 11'h019, 0, 0, 1, 12'hBBB, 0, "R6 new page present");
    lookup(16'h0060, 11'h01A, 0, 0, 1, 12'h606, 0, "R6 later slot kept");
    lookup(16'h00A0, 11'h01B, 0, 0, 1, 12'hAAA, 0, "R8 same-cycle hit kept slot 0");

    // R1/R10 flush with a simultaneous fill
    fill(16'h00C0, 12'hCCC, 0, 1);
    lookup(16'h0020, 11'h01C, 0, 0, 0, '0, 0, "R1 flush drops all");
    lookup(16'h00C0, 11'h01D, 0, 0, 0, '0, 0, "R10 fill during flush dropped");
    fill(16'h00D0, 12'hDDD, 1, 0);
    lookup(16'h00D0, 11'h01E, 0, 0, 1, 12'hDDD, 1, "R5 refill after flush");

    repeat (2) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing responses: got %0d pending, expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule